// File: doc/BRIEF.md
# Double-Buffered DAC Command Controller

This block sits behind a two-wire bus receiver and turns the byte stream of a write transfer aimed at this device into DAC codes. The receiver reports when a START appears on the bus, when this device's address has matched, each complete byte after the address, and when a STOP appears. Bytes after the address alternate between a command byte and an output byte. The last byte of a transfer may be a command byte on its own.

Each DAC channel has two levels of storage. A pending latch takes output bytes as they arrive. A visible latch drives the code output. The power-down choice is held the same way. Nothing visible changes until a STOP ends a transfer that selected this device and carried at least one command byte. At that point every channel and the power-down state move together.

A receiver delivers only complete bytes. A byte cut short by a STOP therefore never arrives, and the early-STOP rules follow from the commit rule alone.

The command byte uses these bit positions: bit 4 is the clear bit, bit 3 is the power-down bit, and bit 2 is the channel select. Bits 7..5 are reserved and bits 1..0 are don't-care.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: After reset, every channel code is 0x00 and out_en_o is 1.
- R2: An output byte is written into the pending latch of the channel named by bit 2 of the command byte before it (0 selects channel 0, which is code_o[7:0]; 1 selects channel 1, which is code_o[15:8]). The code outputs do not change until STOP.
- R3: A STOP that ends a selected transfer containing at least one command byte copies every pending latch into its visible latch. All channels change in the same cycle, and the new value appears on the clock edge that samples stop_i.
- R4: A command byte with no output byte after it changes no pending channel data. Only its power-down bit and clear bit take effect.
- R5: The power-down bit (bit 3) of the last command byte in a transfer decides the state at STOP: 1 drives out_en_o to 0, and 0 drives it to 1. out_en_o changes only on a STOP.
- R6: A command with the power-down bit set, followed by an output byte, still loads that byte, and the byte reaches the code output at STOP.
- R7: A command with the clear bit (bit 4) set zeroes all pending latches at once and discards the next output byte. Later command/output pairs load normally, and the codes stay unchanged until STOP.
- R8: A STOP in a selected transfer with no complete command byte changes nothing. A STOP right after a command byte applies that command's power-down and clear bits.
- R9: A START deselects the device. STOP and bytes that arrive before the next address match are ignored, and the pending data stays loaded. It is committed by a later selected transfer that carries a command byte and ends with STOP.
- R10: Nonzero reserved bits (7..5) in a command byte have no effect.
- R11: Bytes received while the device is not selected are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| sel_i | input | 1 | One-cycle pulse: this device's write address matched |
| stop_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| byte_vld_i | input | 1 | One-cycle strobe: a complete byte after the address |
| byte_i | input | 8 | Received byte, valid with byte_vld_i |
| code_o | output | NUM_CH*8 | Visible codes; channel n is at [8n+7:8n] |
| out_en_o | output | 1 | 1 when the outputs are driven, 0 when powered down |

## Verification
The hardest case to reach is pending data that was loaded and then left uncommitted: a repeated START moves to another device, and that device's bytes and STOP then pass by unclaimed. The bench loads channel 0, fires START, and sends a foreign byte and a STOP. It then opens a new selected transfer that ends with an empty STOP and checks that nothing moved. Only after that does a lone command and STOP release the stale byte. Clear-then-discard ordering and power-down entry and exit are each driven through their own transfers, with the codes checked before and after STOP.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CLR_BIT = 4;
  localparam int unsigned PD_BIT  = 3;
  localparam int unsigned CH_MSB  = 2;

  typedef struct packed {
    logic clr;
    logic pd;
  } cmd_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int unsigned CH_W = 1
) (
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_t              cmd_o,
  output logic [CH_W-1:0]   ch_o
);
  // channel field grows downward into the don't-care bits
  always_comb begin
    cmd_o.clr = byte_i[CLR_BIT];
    cmd_o.pd  = byte_i[PD_BIT];
    ch_o      = byte_i[CH_MSB -: CH_W];
  end
endmodule

// File: rtl/dac_xfer_seq.sv
module dac_xfer_seq
  import dac_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sel_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  cmd_t              cmd_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic              selected_o,
  output logic [NUM_CH-1:0] wr_o,
  output logic              clr_o,
  output logic              commit_o,
  output logic              pd_o
);
  logic            exp_out_q, got_cmd_q, discard_q, pend_pd_q, pd_q;
  logic [CH_W-1:0] ch_q;
  logic            take_cmd, take_out;

  assign take_cmd = selected_o & byte_vld_i & ~exp_out_q & ~stop_i & ~start_i;
  assign take_out = selected_o & byte_vld_i &  exp_out_q & ~stop_i & ~start_i;
  assign clr_o    = take_cmd & cmd_i.clr;
  assign commit_o = selected_o & stop_i & got_cmd_q;
  assign pd_o     = pd_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    assign wr_o[g] = take_out & ~discard_q & (ch_q == CH_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      selected_o <= 1'b0;
      exp_out_q  <= 1'b0;
      got_cmd_q  <= 1'b0;
      discard_q  <= 1'b0;
      pend_pd_q  <= 1'b0;
      pd_q       <= 1'b0;
      ch_q       <= '0;
    end else begin
      if (commit_o) pd_q <= pend_pd_q;
      if (stop_i || start_i) begin
        selected_o <= 1'b0;
      end else if (sel_i) begin
        selected_o <= 1'b1;
        exp_out_q  <= 1'b0;
        got_cmd_q  <= 1'b0;
        discard_q  <= 1'b0;
      end else if (take_cmd) begin
        got_cmd_q <= 1'b1;
        pend_pd_q <= cmd_i.pd;
        discard_q <= cmd_i.clr;
        ch_q      <= ch_i;
        exp_out_q <= 1'b1;
      end else if (take_out) begin
        discard_q <= 1'b0;
        exp_out_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dac_chan_latch.sv
module dac_chan_latch
  import dac_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic              commit_i,
  input  logic [BYTE_W-1:0] din_i,
  output logic [BYTE_W-1:0] code_o
);
  logic [BYTE_W-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      code_o <= '0;
    end else begin
      if (clr_i)     pend_q <= '0;
      else if (wr_i) pend_q <= din_i;
      if (commit_i)  code_o <= pend_q;
    end
  end
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     sel_i,
  input  logic                     stop_i,
  input  logic                     byte_vld_i,
  input  logic [BYTE_W-1:0]        byte_i,
  output logic [NUM_CH*BYTE_W-1:0] code_o,
  output logic                     out_en_o
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  cmd_t              cmd;
  logic [CH_W-1:0]   ch;
  logic              selected;
  logic [NUM_CH-1:0] wr;
  logic              clr, commit, pd;

  dac_cmd_decode #(.CH_W(CH_W)) u_dec (
    .byte_i (byte_i),
    .cmd_o  (cmd),
    .ch_o   (ch)
  );

  dac_xfer_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sel_i      (sel_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .cmd_i      (cmd),
    .ch_i       (ch),
    .selected_o (selected),
    .wr_o       (wr),
    .clr_o      (clr),
    .commit_o   (commit),
    .pd_o       (pd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan_latch u_lat (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr[g]),
      .clr_i    (clr),
      .commit_i (commit),
      .din_i    (byte_i),
      .code_o   (code_o[g*BYTE_W +: BYTE_W])
    );
  end

  assign out_en_o = ~pd;
endmodule

// File: rtl/dac_cmd_chk.sv
module dac_cmd_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         stop_i,
  input logic         selected_i,
  input logic [W-1:0] code_i,
  input logic         out_en_i
);
  a_r3_code_moves_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_i) |-> $past(stop_i));

  a_r5_en_moves_at_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_en_i) |-> $past(stop_i));

  a_r9_start_deselects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !selected_i);

  a_r11_idle_stop_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !selected_i) |=> ($stable(code_i) && $stable(out_en_i)));
endmodule

bind dac_cmd_ctrl dac_cmd_chk #(.W(NUM_CH*8)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .selected_i (selected),
  .code_i     (code_o),
  .out_en_i   (out_en_o)
);

// File: tb/sim_dac_cmd_ctrl.sv
module sim_dac_cmd_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, sel_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic [15:0] code_o;
  logic        out_en_o;
  int          checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  dac_cmd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .sel_i(sel_i),
    .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .code_o(code_o), .out_en_o(out_en_o)
  );

  task automatic chk(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [7:0] c1, input logic [7:0] c0, input logic en);
    chk(tag, {out_en_o, code_o}, {en, c1, c0});
  endtask

  task automatic do_sel();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; sel_i = 1'b1;
    @(negedge clk); sel_i = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0; byte_i = 8'h00;
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1 reset state", 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_pairs();
    do_sel();
    do_byte(8'h00); do_byte(8'hA5);
    chk_out("R2 held before stop", 8'h00, 8'h00, 1'b1);
    do_byte(8'h04); do_byte(8'h3C);
    chk_out("R2 second pair held", 8'h00, 8'h00, 1'b1);
    do_stop();
    chk_out("R3 both channels at stop", 8'h3C, 8'hA5, 1'b1);
  endtask

  task automatic t_pd_last_wins();
    do_sel();
    do_byte(8'h08); do_byte(8'h11); do_byte(8'h04);
    do_stop();
    chk_out("R5 last command clears pd, R4 lone cmd keeps ch1", 8'h3C, 8'h11, 1'b1);
    do_sel();
    do_byte(8'h08);
    chk_out("R5 en held before stop", 8'h3C, 8'h11, 1'b1);
    do_stop();
    chk_out("R5 power down at stop, R4 codes kept", 8'h3C, 8'h11, 1'b0);
  endtask

  task automatic t_pd_with_data();
    do_sel();
    do_byte(8'h0C); do_byte(8'h77);
    do_stop();
    chk_out("R6 data committed while powered down", 8'h77, 8'h11, 1'b0);
    do_sel();
    do_byte(8'h00);
    do_stop();
    chk_out("R5 leave power down", 8'h77, 8'h11, 1'b1);
  endtask

  task automatic t_clear();
    do_sel();
    do_byte(8'h10); do_byte(8'h55);
    do_byte(8'h04); do_byte(8'h99);
    chk_out("R7 codes held before stop", 8'h77, 8'h11, 1'b1);
    do_stop();
    chk_out("R7 clear, discard, then load", 8'h99, 8'h00, 1'b1);
  endtask

  task automatic t_reserved();
    do_sel();
    do_byte(8'hE4); do_byte(8'h42);
    do_stop();
    chk_out("R10 reserved bits ignored", 8'h42, 8'h00, 1'b1);
  endtask

  task automatic t_early_stop();
    do_sel();
    do_stop();
    chk_out("R8 stop with no command", 8'h42, 8'h00, 1'b1);
    do_sel();
    do_byte(8'h08);
    do_stop();
    chk_out("R8 pd of interrupted pair applied", 8'h42, 8'h00, 1'b0);
    do_sel();
    do_byte(8'h10);
    do_stop();
    chk_out("R8 clear of interrupted pair applied", 8'h00, 8'h00, 1'b1);
  endtask

  task automatic t_repeated_start();
    do_sel();
    do_byte(8'h00); do_byte(8'h33);
    do_start();
    do_byte(8'h12);
    do_stop();
    chk_out("R9 foreign stop ignored", 8'h00, 8'h00, 1'b1);
    do_sel();
    do_stop();
    chk_out("R9 empty transfer keeps pending", 8'h00, 8'h00, 1'b1);
    do_sel();
    do_byte(8'h04);
    do_stop();
    chk_out("R9 stale pending committed", 8'h00, 8'h33, 1'b1);
  endtask

  task automatic t_unselected();
    do_byte(8'h00); do_byte(8'hFF);
    do_stop();
    chk_out("R11 unselected stop inert", 8'h00, 8'h33, 1'b1);
    do_sel();
    do_byte(8'h00);
    do_stop();
    chk_out("R11 unselected bytes not loaded", 8'h00, 8'h33, 1'b1);
  endtask

  initial begin
    #(CLK_P*20000);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_pairs();
    t_pd_last_wins();
    t_pd_with_data();
    t_clear();
    t_reserved();
    t_early_stop();
    t_repeated_start();
    t_unselected();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule